// File: doc/BRIEF.md
# USB Host Port State Controller

This block sequences the bus state of one USB host port from four software control bits: session enable, suspend, resume and reset. It tells an external line driver when to produce reset or resume signaling, and it gates the frame counter and the transaction scheduler with two enable outputs. Two line-state inputs are watched for a device attaching, and their polarity at that moment gives the device speed. A bus-activity input, sampled on each frame-end pulse, reveals a device that keeps talking past the end of a frame (babble).

The controller is a single Moore state machine with nine states. `S_OFF` is taken whenever the session bit is low, from any state. `S_OFF` goes to `S_WAIT` once the session bit is high. `S_WAIT` goes to `S_ATTACHED` when the debouncer reports a stable idle line. `S_ATTACHED` goes to `S_RESET` on the reset bit. `S_RESET` goes to `S_ACTIVE` when the reset bit drops. `S_ACTIVE` goes to `S_RESET` on the reset bit, to `S_BABBLE` on a busy frame end, or to `S_DRAIN` on the suspend bit, checked in that order. `S_DRAIN` goes to `S_RESET` on the reset bit, or to `S_SUSPENDED` once the running transaction is done. `S_SUSPENDED` goes to `S_RESET` on the reset bit, or to `S_RESUME` on the resume bit. `S_RESUME` goes to `S_RESET` on the reset bit, or to `S_ACTIVE` when the resume bit drops. `S_BABBLE` leaves only for `S_RESET`, or for `S_OFF` when the session ends.

Software drives the control bits directly. It is expected to hold reset and resume for the bus-mandated time itself; the block only follows their levels.

Top module: `usbh_port_ctrl`

## Requirements
- R1: While `sess_en` is low, the state returns to `S_OFF` at the next clock. In `S_OFF`, every enable and drive output is low and both speed flags read 0.
- R2: An attach is accepted only after the line has been idle (exactly one of `line_dp`/`line_dm` high) with unchanged polarity for DEBOUNCE_CYC consecutive clocks in `S_WAIT`. A single-ended zero or a polarity change restarts the count. An accepted attach gives a one-cycle `irq_connect` pulse in the first cycle of `S_ATTACHED`.
- R3: At attach, `dev_fs` takes the value of `line_dp` and `dev_ls` the value of `line_dm`. The flags hold until the session ends, and at most one of them is high.
- R4: In `S_ATTACHED`, `frame_en` and `sched_en` stay low until a bus reset has been issued and released.
- R5: `drv_reset` is high for as long as `reset_req` stays high. The clock after `reset_req` falls, both `frame_en` and `sched_en` are high.
- R6: `reset_req` overrides `susp_req`, `resume_req` and a latched babble in every state after attach.
- R7: On `susp_req` in `S_ACTIVE`, `sched_en` drops at once. `frame_en` stays high while `xfer_busy` is high, and both are low once `xfer_busy` is low.
- R8: From `S_SUSPENDED`, `resume_req` drives `drv_resume` high for as long as the bit stays high. The clock after it falls, frame counting and scheduling resume.
- R9: In `S_ACTIVE`, a `frame_end` pulse with `bus_active` high halts traffic: `frame_en` and `sched_en` go low and `irq_babble` pulses for one cycle.
- R10: Once babble has halted the port, `resume_req` and `susp_req` have no effect. Only `reset_req` or a low `sess_en` leaves that state.
- R11: `frame_end` with `bus_active` low, or any `frame_end` outside `S_ACTIVE`, raises no babble and changes no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_en | input | 1 | Software session enable |
| susp_req | input | 1 | Software suspend request |
| resume_req | input | 1 | Software resume request (level) |
| reset_req | input | 1 | Software bus reset request (level) |
| line_dp | input | 1 | Received D+ line level |
| line_dm | input | 1 | Received D- line level |
| xfer_busy | input | 1 | A transaction is in progress |
| bus_active | input | 1 | The bus is not idle |
| frame_end | input | 1 | One-cycle pulse at the end of each frame |
| frame_en | output | 1 | Frame counter run enable |
| sched_en | output | 1 | Transaction scheduler may start transactions |
| drv_reset | output | 1 | Request reset signaling on the bus |
| drv_resume | output | 1 | Request resume signaling on the bus |
| irq_connect | output | 1 | One-cycle device-attach interrupt |
| irq_babble | output | 1 | One-cycle babble interrupt |
| dev_fs | output | 1 | Attached device is full speed |
| dev_ls | output | 1 | Attached device is low speed |

## Verification
The bench first puts a single-ended-zero glitch into the attach window and checks that no connect is reported at the cycle a clean line would have produced one. A debouncer that fails to restart would report the attach early. It then times a clean low-speed attach to the exact cycle, which catches an off-by-one count. Reset is asserted together with suspend, and together with a pending babble. A wrong priority would show as suspend being entered or the halt persisting. Suspend is issued during a busy transaction, so a design that stops the frame counter too early, or never, fails. A frame end is also applied while suspended and on a quiet bus, where a loose babble detector would fire.

// File: rtl/usbh_port_pkg.sv
package usbh_port_pkg;

    typedef enum logic [3:0] {
        S_OFF       = 4'd0,
        S_WAIT      = 4'd1,
        S_ATTACHED  = 4'd2,
        S_RESET     = 4'd3,
        S_ACTIVE    = 4'd4,
        S_DRAIN     = 4'd5,
        S_SUSPENDED = 4'd6,
        S_RESUME    = 4'd7,
        S_BABBLE    = 4'd8
    } port_state_e;

    // Driver request pair handed to the line driver
    typedef struct packed {
        logic reset_sig;
        logic resume_sig;
    } drv_req_t;

endpackage

// File: rtl/usbh_attach_debounce.sv
module usbh_attach_debounce #(
    parameter int DEBOUNCE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_dp,
    input  logic line_dm,
    output logic attach
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             dp_prev_q;
    logic             idle_now;
    logic             same_pol;

    // Idle: exactly one line high (J state of either speed)
    assign idle_now = line_dp ^ line_dm;
    assign same_pol = (line_dp == dp_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            dp_prev_q <= 1'b0;
        end else begin
            dp_prev_q <= line_dp;
            if (!enable || !idle_now || !same_pol) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign attach = enable && idle_now && same_pol && (cnt_q == CNT_LAST);

endmodule

// File: rtl/usbh_frame_monitor.sv
module usbh_frame_monitor (
    input  logic enable,
    input  logic frame_end,
    input  logic bus_active,
    output logic babble_hit
);
    // Traffic still present when the frame closes means a runaway device
    always_comb begin
        babble_hit = 1'b0;
        if (enable && frame_end) begin
            babble_hit = bus_active;
        end
    end

endmodule

// File: rtl/usbh_port_fsm.sv
module usbh_port_fsm
    import usbh_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sess_en,
    input  logic     susp_req,
    input  logic     resume_req,
    input  logic     reset_req,
    input  logic     xfer_busy,
    input  logic     attach,
    input  logic     babble_hit,
    input  logic     line_dp,
    input  logic     line_dm,
    output logic     wait_attach,
    output logic     frame_en,
    output logic     sched_en,
    output drv_req_t drv,
    output logic     irq_connect,
    output logic     irq_babble,
    output logic     dev_fs,
    output logic     dev_ls
);
    port_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!sess_en) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:       state_d = S_WAIT;
                S_WAIT:      if (attach) state_d = S_ATTACHED;
                S_ATTACHED:  if (reset_req) state_d = S_RESET;
                S_RESET:     if (!reset_req) state_d = S_ACTIVE;
                S_ACTIVE: begin
                    if (reset_req)       state_d = S_RESET;
                    else if (babble_hit) state_d = S_BABBLE;
                    else if (susp_req)   state_d = S_DRAIN;
                end
                S_DRAIN: begin
                    if (reset_req)       state_d = S_RESET;
                    else if (!xfer_busy) state_d = S_SUSPENDED;
                end
                S_SUSPENDED: begin
                    if (reset_req)       state_d = S_RESET;
                    else if (resume_req) state_d = S_RESUME;
                end
                S_RESUME: begin
                    if (reset_req)        state_d = S_RESET;
                    else if (!resume_req) state_d = S_ACTIVE;
                end
                S_BABBLE:    if (reset_req) state_d = S_RESET;
                default:     state_d = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Moore outputs
    always_comb begin
        wait_attach    = 1'b0;
        frame_en       = 1'b0;
        sched_en       = 1'b0;
        drv.reset_sig  = 1'b0;
        drv.resume_sig = 1'b0;
        unique case (state_q)
            S_WAIT:    wait_attach    = 1'b1;
            S_RESET:   drv.reset_sig  = 1'b1;
            S_ACTIVE: begin
                frame_en = 1'b1;
                sched_en = 1'b1;
            end
            S_DRAIN:   frame_en       = 1'b1;
            S_RESUME:  drv.resume_sig = 1'b1;
            default: ;
        endcase
    end

    // Interrupt pulses and latched speed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_connect <= 1'b0;
            irq_babble  <= 1'b0;
            dev_fs      <= 1'b0;
            dev_ls      <= 1'b0;
        end else begin
            irq_connect <= (state_q != S_ATTACHED) && (state_d == S_ATTACHED);
            irq_babble  <= (state_q != S_BABBLE) && (state_d == S_BABBLE);
            if (state_d == S_OFF) begin
                dev_fs <= 1'b0;
                dev_ls <= 1'b0;
            end else if (state_q == S_WAIT && state_d == S_ATTACHED) begin
                dev_fs <= line_dp;
                dev_ls <= line_dm;
            end
        end
    end

endmodule

// File: rtl/usbh_port_ctrl.sv
module usbh_port_ctrl
    import usbh_port_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sess_en,
    input  logic susp_req,
    input  logic resume_req,
    input  logic reset_req,
    input  logic line_dp,
    input  logic line_dm,
    input  logic xfer_busy,
    input  logic bus_active,
    input  logic frame_end,
    output logic frame_en,
    output logic sched_en,
    output logic drv_reset,
    output logic drv_resume,
    output logic irq_connect,
    output logic irq_babble,
    output logic dev_fs,
    output logic dev_ls
);
    logic     wait_attach;
    logic     attach;
    logic     babble_hit;
    drv_req_t drv;

    usbh_attach_debounce #(
        .DEBOUNCE_CYC(DEBOUNCE_CYC)
    ) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (wait_attach),
        .line_dp (line_dp),
        .line_dm (line_dm),
        .attach  (attach)
    );

    usbh_frame_monitor u_monitor (
        .enable     (sched_en),
        .frame_end  (frame_end),
        .bus_active (bus_active),
        .babble_hit (babble_hit)
    );

    usbh_port_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sess_en     (sess_en),
        .susp_req    (susp_req),
        .resume_req  (resume_req),
        .reset_req   (reset_req),
        .xfer_busy   (xfer_busy),
        .attach      (attach),
        .babble_hit  (babble_hit),
        .line_dp     (line_dp),
        .line_dm     (line_dm),
        .wait_attach (wait_attach),
        .frame_en    (frame_en),
        .sched_en    (sched_en),
        .drv         (drv),
        .irq_connect (irq_connect),
        .irq_babble  (irq_babble),
        .dev_fs      (dev_fs),
        .dev_ls      (dev_ls)
    );

    assign drv_reset  = drv.reset_sig;
    assign drv_resume = drv.resume_sig;

endmodule

// File: rtl/usbh_port_ctrl_chk.sv
module usbh_port_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sess_en,
    input logic susp_req,
    input logic resume_req,
    input logic reset_req,
    input logic xfer_busy,
    input logic bus_active,
    input logic frame_end,
    input logic frame_en,
    input logic sched_en,
    input logic drv_reset,
    input logic drv_resume,
    input logic irq_connect,
    input logic irq_babble,
    input logic dev_fs,
    input logic dev_ls
);
    p_sess_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sess_en |=> (!frame_en && !sched_en && !drv_reset && !drv_resume && !dev_fs && !dev_ls));

    p_connect_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_connect |=> !irq_connect);

    p_speed_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_fs, dev_ls}));

    p_reset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_reset && reset_req && sess_en) |=> drv_reset);

    p_reset_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_reset && !reset_req && sess_en) |=> (frame_en && sched_en));

    p_reset_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_en && sess_en && reset_req && susp_req) |=> drv_reset);

    p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && !sched_en && xfer_busy && sess_en && !reset_req) |=> (frame_en && !sched_en));

    p_resume_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_resume && resume_req && sess_en && !reset_req) |=> drv_resume);

    p_babble_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_en && sess_en && !reset_req && bus_active && frame_end) |=> (irq_babble && !sched_en && !frame_en));

    p_babble_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_babble && sess_en && !reset_req) |=> (!sched_en && !frame_en && !drv_resume));

    p_quiet_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_en && sess_en && !reset_req && !bus_active && !susp_req) |=> (sched_en && !irq_babble));

endmodule

bind usbh_port_ctrl usbh_port_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sess_en     (sess_en),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .reset_req   (reset_req),
    .xfer_busy   (xfer_busy),
    .bus_active  (bus_active),
    .frame_end   (frame_end),
    .frame_en    (frame_en),
    .sched_en    (sched_en),
    .drv_reset   (drv_reset),
    .drv_resume  (drv_resume),
    .irq_connect (irq_connect),
    .irq_babble  (irq_babble),
    .dev_fs      (dev_fs),
    .dev_ls      (dev_ls)
);

// File: tb/tb_usbh_port_ctrl.sv
module tb_usbh_port_ctrl;
    localparam int D = 16;
    localparam int NVEC = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sess_en = 0, susp_req = 0, resume_req = 0, reset_req = 0;
    logic line_dp = 0, line_dm = 0, xfer_busy = 0, bus_active = 0, frame_end = 0;
    logic frame_en, sched_en, drv_reset, drv_resume, irq_connect, irq_babble, dev_fs, dev_ls;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usbh_port_ctrl #(.DEBOUNCE_CYC(D)) dut (
        .clk(clk), .rst_n(rst_n), .sess_en(sess_en), .susp_req(susp_req),
        .resume_req(resume_req), .reset_req(reset_req), .line_dp(line_dp),
        .line_dm(line_dm), .xfer_busy(xfer_busy), .bus_active(bus_active),
        .frame_end(frame_end), .frame_en(frame_en), .sched_en(sched_en),
        .drv_reset(drv_reset), .drv_resume(drv_resume), .irq_connect(irq_connect),
        .irq_babble(irq_babble), .dev_fs(dev_fs), .dev_ls(dev_ls)
    );

    // Inputs {sess,susp,resume,reset,busy,active,fend} | expected {frame,sched,drv_reset,drv_resume,irq_babble,irq_connect}
    localparam logic [12:0] VEC [0:NVEC-1] = '{
        13'b1000000_000000, // 0  R4 attached, idle
        13'b1001000_001000, // 1  R5 reset asserted
        13'b1001000_001000, // 2  R5 reset held
        13'b1000000_110000, // 3  R5 reset released
        13'b1000110_110000, // 4  R11 busy, no frame end
        13'b1100100_100000, // 5  R7 suspend while busy
        13'b1100100_100000, // 6  R7 still draining
        13'b1100000_000000, // 7  R7 drained, suspended
        13'b1100011_000000, // 8  R11 frame end while suspended
        13'b1010000_000100, // 9  R8 resume asserted
        13'b1010000_000100, // 10 R8 resume held
        13'b1000000_110000, // 11 R8 resume released
        13'b1000010_110000, // 12 R11 activity mid frame
        13'b1000001_110000, // 13 R11 quiet frame end
        13'b1101000_001000, // 14 R6 reset with suspend
        13'b1100000_110000, // 15 R5 release, suspend still set
        13'b1100000_100000, // 16 R7 drain with no transaction
        13'b1100000_000000, // 17 R7 suspended
        13'b1101000_001000, // 18 R6 reset from suspended
        13'b1000000_110000, // 19 R5 back to active
        13'b1000011_000010, // 20 R9 busy frame end
        13'b1000000_000000, // 21 R10 halt latched
        13'b1010000_000000, // 22 R10 resume ignored
        13'b1001000_001000, // 23 R10 reset clears halt
        13'b1000000_110000  // 24 R5 active again
    };
    localparam int VREQ [0:NVEC-1] = '{4,5,5,5,11,7,7,7,11,8,8,8,11,11,6,5,7,7,6,5,9,10,10,10,5};

    function automatic logic [5:0] outs();
        return {frame_en, sched_en, drv_reset, drv_resume, irq_babble, irq_connect};
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic seen;
        // Reset state (R1)
        line_dp = 1'b1; line_dm = 1'b0;
        repeat (3) tick();
        check("R1 reset", {outs(), dev_fs, dev_ls}, 8'b0);
        rst_n = 1'b1;
        tick();
        check("R1 session off", {outs(), dev_fs, dev_ls}, 8'b0);

        // Full-speed attach with an SE0 glitch (R2)
        sess_en = 1'b1;
        repeat (3) tick();
        line_dp = 1'b0;
        tick();
        line_dp = 1'b1;
        repeat (D + 1 - 4) tick();
        check("R2 glitch restarts debounce", {6'b0, irq_connect, dev_fs}, 8'b0);
        seen = 1'b0;
        for (int i = 0; i < 2 * D && !seen; i++) begin
            tick();
            seen = irq_connect;
        end
        check("R2 connect after glitch", {7'b0, seen}, 8'd1);
        check("R3 full speed flag", {6'b0, dev_fs, dev_ls}, 8'b10);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            {sess_en, susp_req, resume_req, reset_req, xfer_busy, bus_active, frame_end} = VEC[v][12:6];
            tick();
            check($sformatf("R%0d vector %0d", VREQ[v], v), {2'b0, outs()}, {2'b0, VEC[v][5:0]});
        end
        {susp_req, resume_req, reset_req, xfer_busy, bus_active, frame_end} = '0;

        // Session off from active (R1)
        sess_en = 1'b0;
        tick();
        check("R1 session off clears", {outs(), dev_fs, dev_ls}, 8'b0);

        // Exact-cycle low-speed attach (R2, R3)
        line_dp = 1'b0; line_dm = 1'b1;
        tick();
        sess_en = 1'b1;
        repeat (D) tick();
        check("R2 no connect before count", {6'b0, irq_connect, dev_ls}, 8'b0);
        tick();
        check("R2 connect pulse", {7'b0, irq_connect}, 8'd1);
        check("R3 low speed flag", {6'b0, dev_fs, dev_ls}, 8'b01);
        tick();
        check("R2 pulse ends", {7'b0, irq_connect}, 8'd0);

        // Babble cleared by session end (R10)
        reset_req = 1'b1; tick();
        reset_req = 1'b0; tick();
        check("R5 active after reset", {2'b0, outs()}, 8'b00110000);
        bus_active = 1'b1; frame_end = 1'b1; tick();
        bus_active = 1'b0; frame_end = 1'b0;
        check("R9 babble pulse", {2'b0, outs()}, 8'b00000010);
        susp_req = 1'b1; tick();
        susp_req = 1'b0;
        check("R10 suspend ignored", {2'b0, outs()}, 8'b0);
        sess_en = 1'b0; tick();
        check("R10 session clears babble", {outs(), dev_fs, dev_ls}, 8'b0);
        sess_en = 1'b1; tick();
        check("R4 waiting, nothing enabled", {2'b0, outs()}, 8'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule